// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers the reset requests of a device and spreads them over three reset outputs: one for the core logic, one for the link physical layer and one for the persistent (sticky) register bits. There are two asynchronous active-low pins, a cold power-on reset and a warm reset, plus four link events: hot reset, loopback, disable link and link down. Each source reaches its own set of domains. Only the cold reset clears the persistent domain. The hot, loopback and disable events reach the core alone. Link down also takes the physical layer. The link events count only when the device is an endpoint and its link interface is enabled.

Every output asserts at once, without waiting for a clock, and releases on a clock edge through a two-stage synchronizer. A link event that lasts a single cycle is stretched so that its reset covers a minimum window. When the core reset is released, the block captures the configuration strap pins. After a cold or warm reset the whole vector is taken. After a reset caused only by link events, only a masked subset is refreshed. A one-hot cause register records the most recent source, and only the cold reset clears it.

All pins are plain control and status signals. No data stream passes through the block, so none of its ports uses a valid/ready handshake.

Top module: `rst_fanout_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, `core_rst_n`, `phy_rst_n` and `persist_rst_n` are all low, `strap_val` reads zero and `last_cause` reads 6'b000001 (bit 0 = cold).
- R2: A low on `warm_rst_n` drives `core_rst_n` and `phy_rst_n` low and leaves `persist_rst_n` high. The warm source is recorded in `last_cause` as bit 1 on the third clock edge after the pin falls, which allows for its two-stage input synchronizer.
- R3: An accepted hot-reset, loopback or disable-link event drives only `core_rst_n` low, and `phy_rst_n` and `persist_rst_n` stay high. The cause bits are 2 for hot, 3 for loopback and 4 for disable.
- R4: An accepted link-down event drives `core_rst_n` and `phy_rst_n` low and leaves `persist_rst_n` high. Its cause bit is 5.
- R5: A link event is accepted only in a cycle where `is_endpoint` and `link_enabled` are both high. Otherwise it changes no output and leaves `last_cause` as it was.
- R6: Each output goes low as soon as any request for its domain becomes active, with no clock edge needed. It goes high on the second rising clock edge after the last such request has ended.
- R7: An accepted link event keeps its request active for STRETCH cycles after the last edge that sampled it. A single-cycle pulse therefore holds `core_rst_n` low for STRETCH+2 sampled cycles.
- R8: On the clock edge after `core_rst_n` rises, if the reset episode included cold or warm, `strap_val` takes the whole of `strap_pins`. At no other edge does `strap_val` change.
- R9: If the episode contained only link events, only the bits set in PART_MASK (default 8'h0F, the low four bits) are taken from `strap_pins`. The other bits keep their value.
- R10: Sources that are active together are ORed into each domain. An episode that mixes warm and link events captures the whole strap vector.
- R11: `last_cause` is always one-hot and shows the most recent source. When several sources are seen at the same edge, the winner is chosen in the order warm, link down, disable, loopback, hot. Only cold reset brings it back to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of all destination domains |
| cold_rst_n | input | 1 | Cold power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| is_endpoint | input | 1 | Device operates as a link endpoint |
| link_enabled | input | 1 | Link interface enabled |
| lk_hot | input | 1 | Hot-reset event (pulse or level) |
| lk_loop | input | 1 | Loopback event (pulse or level) |
| lk_disable | input | 1 | Disable-link event (pulse or level) |
| lk_down | input | 1 | Link-down event (pulse or level) |
| strap_pins | input | STRAP_W | Configuration strap inputs |
| core_rst_n | output | 1 | Core-logic reset, active low |
| phy_rst_n | output | 1 | Link physical-layer reset, active low |
| persist_rst_n | output | 1 | Persistent-bit reset, active low |
| strap_val | output | STRAP_W | Captured strap vector |
| last_cause | output | 6 | One-hot code of the most recent reset source |

## Verification
The bench builds the block with its default parameters: an 8-bit strap vector, a partial mask of 8'h0F and a stretch of 16 cycles. With a 16-cycle stretch, the full release window of every link event fits within a few dozen cycles, so the bench can count the exact low time of a single pulse, and it can also overlap warm and link episodes. A mask that covers exactly half the vector means that every partial capture shows refreshed bits and kept bits side by side, so a mix-up between full and partial capture is plain to see in the captured value.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // Source indices inside the one-hot cause vector
  localparam int SRC_COLD  = 0;
  localparam int SRC_WARM  = 1;
  localparam int LINK_BASE = 2;  // hot, loop, disable, down follow in this order
  localparam int NUM_LINK  = 4;
  localparam int NUM_SRC   = LINK_BASE + NUM_LINK;

  // Link event indices
  localparam int LK_HOT  = 0;
  localparam int LK_LOOP = 1;
  localparam int LK_DIS  = 2;
  localparam int LK_DOWN = 3;

  // Reset domains
  localparam int DOM_CORE    = 0;
  localparam int DOM_PHY     = 1;
  localparam int DOM_PERSIST = 2;
  localparam int NUM_DOM     = 3;

  // Which link events also reach the physical layer
  localparam logic [NUM_LINK-1:0] LINK_TO_PHY = 4'b1000;

  typedef logic [NUM_SRC-1:0]  cause_t;
  typedef logic [NUM_LINK-1:0] link_vec_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge arst) begin
        if (arst) ff <= '0;
        else      ff <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge arst) begin
        if (arst) ff <= '0;
        else      ff <= {ff[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n = ff[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic fire,
  output logic busy
);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [CNT_W-1:0] cnt;

  // Reload on every accepted cycle, then run down to zero
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)     cnt <= '0;
    else if (fire)       cnt <= CNT_W'(STRETCH);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rstc_strap.sv
module rstc_strap #(
  parameter int                   STRAP_W   = 8,
  parameter logic [STRAP_W-1:0]   PART_MASK = 8'h0F
) (
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               hard_req,
  input  logic               core_rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic [STRAP_W-1:0] strap_val
);
  logic core_d;
  logic pend_full;
  logic release_now;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) core_d <= 1'b0;
    else             core_d <= core_rst_n;
  end

  assign release_now = core_rst_n & ~core_d;

  // Any pin-driven reset in the episode asks for a full capture
  always_ff @(posedge clk or posedge hard_req) begin
    if (hard_req)         pend_full <= 1'b1;
    else if (release_now) pend_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      strap_val <= '0;
    end else if (release_now) begin
      if (pend_full) strap_val <= strap_pins;
      else           strap_val <= (strap_pins & PART_MASK) | (strap_val & ~PART_MASK);
    end
  end
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic      clk,
  input  logic      cold_rst_n,
  input  logic      warm_rst_n,
  input  link_vec_t link_act,
  output cause_t    last_cause
);
  logic [1:0] warm_sync;
  cause_t     link_code;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) warm_sync <= '0;
    else             warm_sync <= {warm_sync[0], ~warm_rst_n};
  end

  // Higher link index wins: down > disable > loopback > hot
  always_comb begin
    link_code = '0;
    for (int i = 0; i < NUM_LINK; i++) begin
      if (link_act[i]) link_code = cause_t'(1) << (LINK_BASE + i);
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)       last_cause <= cause_t'(1) << SRC_COLD;
    else if (warm_sync[1]) last_cause <= cause_t'(1) << SRC_WARM;
    else if (|link_act)    last_cause <= link_code;
  end
endmodule

// File: rtl/rst_fanout_ctrl.sv
module rst_fanout_ctrl
  import rstc_pkg::*;
#(
  parameter int                 STRAP_W     = 8,
  parameter logic [STRAP_W-1:0] PART_MASK   = 8'h0F,
  parameter int                 STRETCH     = 16,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               warm_rst_n,
  input  logic               is_endpoint,
  input  logic               link_enabled,
  input  logic               lk_hot,
  input  logic               lk_loop,
  input  logic               lk_disable,
  input  logic               lk_down,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic               core_rst_n,
  output logic               phy_rst_n,
  output logic               persist_rst_n,
  output logic [STRAP_W-1:0] strap_val,
  output logic [5:0]         last_cause
);
  link_vec_t             link_raw, link_act, link_busy;
  logic                  link_ok;
  logic                  hard_req;
  logic                  core_req;
  logic [NUM_DOM-1:0]    dom_req, dom_rst_n;

  assign link_raw = {lk_down, lk_disable, lk_loop, lk_hot};
  assign link_ok  = is_endpoint & link_enabled;
  assign link_act = link_raw & {NUM_LINK{link_ok}};

  generate
    for (genvar i = 0; i < NUM_LINK; i++) begin : g_stretch
      rstc_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .fire       (link_act[i]),
        .busy       (link_busy[i])
      );
    end
  endgenerate

  assign hard_req = ~cold_rst_n | ~warm_rst_n;
  assign core_req = hard_req | (|link_busy);

  assign dom_req[DOM_CORE]    = core_req;
  assign dom_req[DOM_PHY]     = hard_req | (|(link_busy & LINK_TO_PHY));
  assign dom_req[DOM_PERSIST] = ~cold_rst_n;

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_sync
      rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .arst  (dom_req[d]),
        .rst_n (dom_rst_n[d])
      );
    end
  endgenerate

  assign core_rst_n    = dom_rst_n[DOM_CORE];
  assign phy_rst_n     = dom_rst_n[DOM_PHY];
  assign persist_rst_n = dom_rst_n[DOM_PERSIST];

  rstc_strap #(.STRAP_W(STRAP_W), .PART_MASK(PART_MASK)) u_strap (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .hard_req   (hard_req),
    .core_rst_n (core_rst_n),
    .strap_pins (strap_pins),
    .strap_val  (strap_val)
  );

  rstc_cause u_cause (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .link_act   (link_act),
    .last_cause (last_cause)
  );
endmodule

// File: rtl/rst_fanout_ctrl_chk.sv
module rst_fanout_ctrl_chk #(
  parameter int STRAP_W = 8
) (
  input logic               clk,
  input logic               cold_rst_n,
  input logic               core_req,
  input logic               core_rst_n,
  input logic               phy_rst_n,
  input logic               persist_rst_n,
  input logic [STRAP_W-1:0] strap_val,
  input logic [5:0]         last_cause
);
  // R1: cold reset holds every domain
  always @(posedge clk) begin
    if (cold_rst_n == 1'b0) begin
      p_cold_all_r1: assert (!core_rst_n && !phy_rst_n && !persist_rst_n)
        else $error("cold reset left a domain released");
    end
  end

  // R2: once released, the persistent domain stays released until cold reset
  p_persist_holds_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $past(persist_rst_n) |-> persist_rst_n);

  // R4: the physical layer is never in reset without the core
  p_phy_in_core_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !phy_rst_n |-> !core_rst_n);

  // R6: core release only after its request has been quiet for two samples
  p_sync_release_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(core_rst_n) |-> (!$past(core_req) && !$past(core_req, 2)));

  // R8: straps move only right after a core release
  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ($past(core_rst_n, 2) && $past(core_rst_n)) |-> $stable(strap_val));

  // R11: cause stays one-hot
  p_cause_onehot_r11: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $countones(last_cause) == 1);
endmodule

bind rst_fanout_ctrl rst_fanout_ctrl_chk #(.STRAP_W(STRAP_W)) u_chk (
  .clk           (clk),
  .cold_rst_n    (cold_rst_n),
  .core_req      (core_req),
  .core_rst_n    (core_rst_n),
  .phy_rst_n     (phy_rst_n),
  .persist_rst_n (persist_rst_n),
  .strap_val     (strap_val),
  .last_cause    (last_cause)
);

// File: tb/test_rst_fanout_ctrl.sv
module test_rst_fanout_ctrl;
  localparam int CLK_P   = 10;
  localparam int SW      = 8;
  localparam logic [SW-1:0] MASK = 8'h0F;
  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic cold = 1'b0, warm = 1'b1, ep = 1'b1, en = 1'b1;
  logic [3:0] ev = 4'b0;            // 0 hot, 1 loop, 2 disable, 3 down
  logic [SW-1:0] straps = 8'hA5;
  logic core_o, phy_o, pers_o;
  logic [SW-1:0] strap_o;
  logic [5:0] cause_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  rst_fanout_ctrl #(.STRAP_W(SW), .PART_MASK(MASK), .STRETCH(STRETCH)) i_rst_fanout_ctrl (
    .clk(clk), .cold_rst_n(cold), .warm_rst_n(warm), .is_endpoint(ep), .link_enabled(en),
    .lk_hot(ev[0]), .lk_loop(ev[1]), .lk_disable(ev[2]), .lk_down(ev[3]),
    .strap_pins(straps), .core_rst_n(core_o), .phy_rst_n(phy_o), .persist_rst_n(pers_o),
    .strap_val(strap_o), .last_cause(cause_o));

  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int cnt[4];
  int qc = 0, qp = 0, qs = 0;
  bit w1 = 0, w2 = 0, cd = 0, pf = 1;
  logic [SW-1:0] m_strap = '0;
  logic [5:0] m_cause = 6'b000001;

  function automatic bit any_link();
    return (cnt[0] > 0) || (cnt[1] > 0) || (cnt[2] > 0) || (cnt[3] > 0);
  endfunction
  function automatic bit m_core_req();
    return !cold || !warm || any_link();
  endfunction
  function automatic bit m_phy_req();
    return !cold || !warm || (cnt[3] > 0);
  endfunction

  initial for (int i = 0; i < 4; i++) cnt[i] = 0;

  always @(posedge clk) begin
    bit cnow, rel, cb, pb;
    bit [3:0] act;
    if (!cold) begin
      for (int i = 0; i < 4; i++) cnt[i] = 0;
      qc = 0; qp = 0; qs = 0; w1 = 0; w2 = 0; cd = 0; pf = 1;
      m_strap = '0; m_cause = 6'b000001;
    end else begin
      cnow = !m_core_req() && qc >= 2;
      rel  = cnow && !cd;
      act  = ev & {4{ep && en}};
      if (w2)          m_cause = 6'b000010;
      else if (act[3]) m_cause = 6'b100000;
      else if (act[2]) m_cause = 6'b010000;
      else if (act[1]) m_cause = 6'b001000;
      else if (act[0]) m_cause = 6'b000100;
      if (rel) m_strap = pf ? straps : ((straps & MASK) | (m_strap & ~MASK));
      if (!warm) pf = 1; else if (rel) pf = 0;
      cd = cnow;
      cb = m_core_req();
      pb = m_phy_req();
      for (int i = 0; i < 4; i++) cnt[i] = act[i] ? STRETCH : (cnt[i] > 0 ? cnt[i] - 1 : 0);
      qc = (cb || m_core_req()) ? 0 : (qc < 2 ? qc + 1 : qc);
      qp = (pb || m_phy_req())  ? 0 : (qp < 2 ? qp + 1 : qp);
      qs = (qs < 2) ? qs + 1 : qs;
      w2 = w1; w1 = !warm;
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // compare every cycle, half a period after the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(phase, "core_rst_n", int'(core_o), int'(!m_core_req() && qc >= 2));
      chk(phase, "phy_rst_n",  int'(phy_o),  int'(!m_phy_req() && qp >= 2));
      chk(phase, "persist_rst_n", int'(pers_o), int'(cold && qs >= 2));
      chk(phase, "strap_val",  int'(strap_o), cold ? int'(m_strap) : 0);
      chk(phase, "last_cause", int'(cause_o), cold ? int'(m_cause) : 1);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #(CLK_P/4); end
  endtask

  task automatic pulse(int idx);
    ev[idx] = 1'b1; step(1); ev[idx] = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lows;
    // R1: cold reset state
    phase = "R1";
    step(4);
    chk("R1", "cause during cold", int'(cause_o), 1);
    cold = 1'b1;
    phase = "R8";
    step(8);
    chk("R8", "full strap after cold", int'(strap_o), 8'hA5);

    // R2 / R6: warm reset, persistent domain untouched
    phase = "R2";
    straps = 8'h3C;
    warm = 1'b0; step(5);
    chk("R2", "persist kept in warm", int'(pers_o), 1);
    chk("R2", "cause warm", int'(cause_o), 6'b000010);
    warm = 1'b1;
    phase = "R6";
    step(8);
    chk("R8", "full strap after warm", int'(strap_o), 8'h3C);

    // R3 / R7 / R9: hot pulse, stretched, partial strap capture
    phase = "R3";
    straps = 8'hFF;
    pulse(0);
    lows = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!core_o) lows++;
    end
    @(posedge clk); #(CLK_P/4);
    chk("R7", "core low cycles for pulse", lows, STRETCH + 2);
    chk("R9", "partial strap", int'(strap_o), 8'h3F);
    chk("R3", "cause hot", int'(cause_o), 6'b000100);
    pulse(1); step(24);
    chk("R3", "cause loopback", int'(cause_o), 6'b001000);
    ev[2] = 1'b1; step(3); ev[2] = 1'b0; step(24);
    chk("R3", "cause disable", int'(cause_o), 6'b010000);

    // R4: link down reaches the physical layer
    phase = "R4";
    straps = 8'h50;
    pulse(3); step(2);
    chk("R4", "phy in reset on link down", int'(phy_o), 0);
    chk("R4", "persist kept on link down", int'(pers_o), 1);
    step(24);
    chk("R9", "partial strap after down", int'(strap_o), 8'h30);

    // R5: events ignored when not endpoint or link disabled
    phase = "R5";
    ep = 1'b0; pulse(0); step(4);
    chk("R5", "core untouched when not endpoint", int'(core_o), 1);
    ep = 1'b1; en = 1'b0;
    ev[3] = 1'b1; step(5); ev[3] = 1'b0; step(3);
    chk("R5", "phy untouched when link off", int'(phy_o), 1);
    chk("R5", "cause unchanged", int'(cause_o), 6'b100000);
    en = 1'b1; step(2);

    // R10: warm and link down together, full capture wins
    phase = "R10";
    straps = 8'h96;
    warm = 1'b0; ev[3] = 1'b1; step(4);
    warm = 1'b1; ev[3] = 1'b0; step(26);
    chk("R10", "full strap after mixed episode", int'(strap_o), 8'h96);
    chk("R10", "cause warm over link", int'(cause_o), 6'b000010);

    // R11: simultaneous events, priority
    phase = "R11";
    ev = 4'b0101; step(1); ev = 4'b0000; step(2);
    chk("R11", "disable beats hot", int'(cause_o), 6'b010000);
    ev = 4'b1010; step(1); ev = 4'b0000; step(2);
    chk("R11", "down beats loopback", int'(cause_o), 6'b100000);
    step(24);

    // R1: cold reset mid-run
    phase = "R1";
    cold = 1'b0; step(3);
    chk("R1", "persist low in cold", int'(pers_o), 0);
    chk("R1", "strap cleared", int'(strap_o), 0);
    chk("R11", "cold clears cause", int'(cause_o), 1);
    cold = 1'b1; step(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule